// File: doc/BRIEF.md
# Instruction Address Sequencer with Return Stack

This block produces the fetch address for a small RISC core whose instructions are 14 bits wide. It keeps a 13-bit program counter that covers an 8K-word instruction space. The instruction store that exists physically holds only 2K words. The fetch port therefore carries only the low 11 counter bits, so addresses above 0x7FF alias back into the physical store.

Each advance strobe marks one instruction cycle. An ordinary cycle steps the counter by one. A jump or call places an 11-bit target in the low counter bits and a 2-bit page value in the upper bits. A call, and an accepted interrupt, also save the return address on an 8-entry circular stack. A return pops that stack. An interrupt sends the counter to the fixed vector 0x0004, and reset sends it to 0x0000. Every change of flow costs one extra cycle. During that bubble cycle a flush indication is raised so that the core can discard the instruction already fetched.

Top module: `iaseq_top`

## Requirements
- R1: While rstN is low, pcValue is 0x0000, fetchAddr is 0x000 and flush is 0. Reset overrides any interrupt request present at the same time.
- R2: In a normal cycle with advance high and no control request, pcValue increases by one. The 13-bit value wraps from 0x1FFF to 0x0000. When advance is low, pcValue and flush hold, and all control inputs are ignored.
- R3: fetchAddr always equals bits 10:0 of pcValue. A counter value of 0x0800 or above therefore fetches from the low 2K words, for example 0x0800 fetches from 0x000.
- R4: A jump loads pcValue with {pageSel, target}, where pageSel forms bits 12:11 and target forms bits 10:0. Bits 12:11 change only on a jump, a call, a return, an interrupt, or by a carry out of bit 10.
- R5: A call pushes pcValue+1 and loads {pageSel, target}. A return pops the top entry into pcValue, restoring all 13 bits.
- R6: An accepted interrupt pushes pcValue+1 and loads 0x0004. The jump, call or return request present in the same cycle is not acted on.
- R7: After any change of flow, the next advance cycle is a bubble. In that cycle flush is 1, pcValue holds, and jump, call and return requests are ignored. The cycle after the bubble is a normal cycle again.
- R8: The stack holds 8 entries and works as a circular buffer. A ninth push overwrites the oldest entry. A return when the stack is empty wraps the pointer. No overflow or underflow is reported.
- R9: An interrupt request seen during a bubble, or while advance is low, is kept pending. It is taken in the next normal advance cycle.
- R10: When a return request and a call request or jump request arrive in the same normal cycle, the return wins. A call wins over a jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| advance | input | 1 | Instruction-cycle strobe |
| jumpReq | input | 1 | Jump to {pageSel, target} |
| callReq | input | 1 | Call: push return address, then jump |
| retReq | input | 1 | Return: pop address into the counter |
| irqReq | input | 1 | Interrupt request (pulse or level) |
| target | input | 11 | Jump and call target, low counter bits |
| pageSel | input | 2 | Page value for counter bits 12:11 |
| fetchAddr | output | 11 | Address into the physical instruction store |
| pcValue | output | 13 | Full program counter |
| flush | output | 1 | High during the bubble after a change of flow |

## Verification
The hardest state to reach is a stack that has wrapped. Getting there takes nine nested calls, each followed by its own bubble cycle, and then nine returns. The final return must read back the entry that overwrote the oldest slot. The stimulus drives that whole sequence with distinct targets, so every saved address is unique. A second hard case is an interrupt pulse that arrives in a bubble, together with an ignored jump. The following plain cycle must then enter the vector, and it must not step the counter.

// File: rtl/iaseq_pkg.sv
package iaseq_pkg;
  // Strobes from the control unit to the datapath; at most one load source per cycle.
  typedef struct packed {
    logic inc;
    logic loadTarget;
    logic loadIrqVec;
    logic push;
    logic pop;
  } seqStrobe_t;
endpackage

// File: rtl/iaseq_ctrl.sv
module iaseq_ctrl
  import iaseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       advance,
  input  logic       jumpReq,
  input  logic       callReq,
  input  logic       retReq,
  input  logic       irqReq,
  output seqStrobe_t strobe,
  output logic       inBubble
);
  typedef enum logic {ST_RUN, ST_BUBBLE} seqState_t;

  seqState_t stateQ;
  logic      irqPendQ;
  logic      active, takeIrq, doRet, doCall, doJump, flowChange;

  always_comb begin
    active     = advance && (stateQ == ST_RUN);
    takeIrq    = active && (irqReq || irqPendQ);
    doRet      = active && !takeIrq && retReq;
    doCall     = active && !takeIrq && !retReq && callReq;
    doJump     = active && !takeIrq && !retReq && !callReq && jumpReq;
    flowChange = takeIrq || doRet || doCall || doJump;

    strobe            = '0;
    strobe.inc        = active && !flowChange;
    strobe.loadTarget = doCall || doJump;
    strobe.loadIrqVec = takeIrq;
    strobe.push       = takeIrq || doCall;
    strobe.pop        = doRet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_RUN;
      irqPendQ <= 1'b0;
    end else begin
      if (advance) begin
        if (stateQ == ST_RUN) stateQ <= flowChange ? ST_BUBBLE : ST_RUN;
        else                  stateQ <= ST_RUN;
      end
      irqPendQ <= takeIrq ? 1'b0 : (irqPendQ || irqReq);
    end
  end

  assign inBubble = (stateQ == ST_BUBBLE);

  // R7: every change of flow is followed by a bubble
  a_r7_bubble_follows: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadTarget || strobe.loadIrqVec || strobe.pop) |=> inBubble);

  // R7: a bubble lasts one advance cycle only
  a_r7_single_bubble: assert property (@(posedge clk) disable iff (!rstN)
    (inBubble && advance) |=> !inBubble);

  // R9: a request seen in a bubble is kept for later
  a_r9_irq_deferred: assert property (@(posedge clk) disable iff (!rstN)
    (inBubble && irqReq) |=> irqPendQ);

  // R10: never two load sources at once
  a_r10_one_source: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.inc, strobe.loadTarget, strobe.loadIrqVec, strobe.pop}));
endmodule

// File: rtl/iaseq_datapath.sv
module iaseq_datapath
  import iaseq_pkg::*;
#(
  parameter int PC_W        = 13,
  parameter int FETCH_W     = 11,
  parameter int STACK_DEPTH = 8,
  parameter int RESET_VEC   = 0,
  parameter int IRQ_VEC     = 4,
  localparam int PAGE_W     = PC_W - FETCH_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strobe,
  input  logic [FETCH_W-1:0] target,
  input  logic [PAGE_W-1:0]  pageSel,
  output logic [PC_W-1:0]    pcQ
);
  localparam int SP_W = $clog2(STACK_DEPTH);
  localparam logic [PC_W-1:0] PC_ONE = 1;
  localparam logic [SP_W-1:0] SP_ONE = 1;
  localparam logic [PC_W-1:0] RST_ADDR = PC_W'(RESET_VEC);
  localparam logic [PC_W-1:0] IRQ_ADDR = PC_W'(IRQ_VEC);

  logic [PC_W-1:0] stackMem [STACK_DEPTH];
  logic [SP_W-1:0] spQ;
  logic [SP_W-1:0] topIdx;
  logic [PC_W-1:0] topEntry, pcPlusOne;

  assign topIdx    = spQ - SP_ONE;
  assign topEntry  = stackMem[topIdx];
  assign pcPlusOne = pcQ + PC_ONE;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ <= RST_ADDR;
      spQ <= '0;
    end else begin
      if (strobe.loadIrqVec)      pcQ <= IRQ_ADDR;
      else if (strobe.pop)        pcQ <= topEntry;
      else if (strobe.loadTarget) pcQ <= {pageSel, target};
      else if (strobe.inc)        pcQ <= pcPlusOne;

      if (strobe.push)     spQ <= spQ + SP_ONE;
      else if (strobe.pop) spQ <= topIdx;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.push) stackMem[spQ] <= pcPlusOne;
  end

  // R2: a plain step adds one
  a_r2_increment: assert property (@(posedge clk) disable iff (!rstN)
    strobe.inc |=> (pcQ == $past(pcQ) + PC_ONE));

  // R2: no strobe, no change
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strobe == '0) |=> $stable(pcQ));

  // R4: page bits come from pageSel on a target load
  a_r4_page_load: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadTarget && !strobe.loadIrqVec) |=> (pcQ[PC_W-1:FETCH_W] == $past(pageSel)));

  // R5: a return restores the saved entry
  a_r5_return: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |=> (pcQ == $past(topEntry)));

  // R6: interrupt enters the vector
  a_r6_vector: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadIrqVec |=> (pcQ == IRQ_ADDR));

  // R8: the pointer steps modulo the depth
  a_r8_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |=> (spQ == $past(spQ) + SP_ONE));
endmodule

// File: rtl/iaseq_top.sv
module iaseq_top
  import iaseq_pkg::*;
#(
  parameter int PC_W        = 13,
  parameter int FETCH_W     = 11,
  parameter int STACK_DEPTH = 8,
  parameter int RESET_VEC   = 0,
  parameter int IRQ_VEC     = 4,
  localparam int PAGE_W     = PC_W - FETCH_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               advance,
  input  logic               jumpReq,
  input  logic               callReq,
  input  logic               retReq,
  input  logic               irqReq,
  input  logic [FETCH_W-1:0] target,
  input  logic [PAGE_W-1:0]  pageSel,
  output logic [FETCH_W-1:0] fetchAddr,
  output logic [PC_W-1:0]    pcValue,
  output logic               flush
);
  seqStrobe_t strobe;

  iaseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .advance(advance),
    .jumpReq(jumpReq), .callReq(callReq), .retReq(retReq), .irqReq(irqReq),
    .strobe(strobe), .inBubble(flush)
  );

  iaseq_datapath #(
    .PC_W(PC_W), .FETCH_W(FETCH_W), .STACK_DEPTH(STACK_DEPTH),
    .RESET_VEC(RESET_VEC), .IRQ_VEC(IRQ_VEC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .target(target), .pageSel(pageSel), .pcQ(pcValue)
  );

  // R3: fetch port aliases into the physical store
  assign fetchAddr = pcValue[FETCH_W-1:0];
endmodule

// File: tb/iaseq_top_tb.sv
module iaseq_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        advance = 1'b0, jumpReq = 1'b0, callReq = 1'b0, retReq = 1'b0, irqReq = 1'b0;
  logic [10:0] target = '0;
  logic [1:0]  pageSel = '0;
  logic [10:0] fetchAddr;
  logic [12:0] pcValue;
  logic        flush;

  int testCnt = 0;
  int failCnt = 0;

  logic [12:0] expPc[$];
  logic        expFl[$];
  string       expTag[$];

  // independent model of the requirements
  logic [12:0] mPc;
  logic        mBubble, mPend;
  logic [12:0] mStack [8];
  logic [2:0]  mSp;

  always #(CLK_PERIOD/2) clk = ~clk;

  iaseq_top u_dut (
    .clk(clk), .rstN(rstN), .advance(advance),
    .jumpReq(jumpReq), .callReq(callReq), .retReq(retReq), .irqReq(irqReq),
    .target(target), .pageSel(pageSel),
    .fetchAddr(fetchAddr), .pcValue(pcValue), .flush(flush)
  );

  task automatic check(string tag, logic [12:0] ePc, logic eFl);
    testCnt++;
    if (pcValue !== ePc || flush !== eFl) begin
      failCnt++;
      $display("FAIL %s: pc=%h flush=%b expected pc=%h flush=%b", tag, pcValue, flush, ePc, eFl);
    end
    testCnt++;
    if (fetchAddr !== ePc[10:0]) begin
      failCnt++;
      $display("FAIL R3: fetch=%h expected %h", fetchAddr, ePc[10:0]);
    end
  endtask

  // monitor: compares one expected item per edge, sampled after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expPc.size() > 0) check(expTag.pop_front(), expPc.pop_front(), expFl.pop_front());
    end
  end

  function automatic void modelReset();
    mPc = '0; mBubble = 1'b0; mPend = 1'b0; mSp = '0;
  endfunction

  // driver: applies one cycle of inputs and queues the expected result
  task automatic step(bit adv, bit j, bit c, bit r, bit i, logic [10:0] tgt, logic [1:0] pg, string tag);
    @(negedge clk);
    advance = adv; jumpReq = j; callReq = c; retReq = r; irqReq = i;
    target = tgt; pageSel = pg;
    if (!adv) begin
      mPend = mPend | i;
    end else if (mBubble) begin
      mBubble = 1'b0;
      mPend = mPend | i;
    end else if (i || mPend) begin
      mStack[mSp] = mPc + 13'd1; mSp = mSp + 3'd1;
      mPc = 13'h0004; mBubble = 1'b1; mPend = 1'b0;
    end else if (r) begin
      mSp = mSp - 3'd1; mPc = mStack[mSp]; mBubble = 1'b1;
    end else if (c) begin
      mStack[mSp] = mPc + 13'd1; mSp = mSp + 3'd1;
      mPc = {pg, tgt}; mBubble = 1'b1;
    end else if (j) begin
      mPc = {pg, tgt}; mBubble = 1'b1;
    end else begin
      mPc = mPc + 13'd1;
    end
    expPc.push_back(mPc); expFl.push_back(mBubble); expTag.push_back(tag);
  endtask

  task automatic plain(string tag);
    step(1, 0, 0, 0, 0, 11'h0, 2'd0, tag);
  endtask

  task automatic doReset(bit irqDuring);
    @(negedge clk);
    rstN = 1'b0; irqReq = irqDuring; advance = 1'b1;
    jumpReq = 1'b0; callReq = 1'b0; retReq = 1'b0;
    modelReset();
    #1;
    check("R1", 13'h0000, 1'b0);
    @(negedge clk);
    #1;
    check("R1", 13'h0000, 1'b0);
    rstN = 1'b1; irqReq = 1'b0; advance = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failCnt++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    modelReset();
    doReset(1'b0);

    // R2: plain steps and holding
    plain("R2"); plain("R2"); plain("R2");
    step(0, 1, 0, 0, 0, 11'h555, 2'd3, "R2");
    step(0, 0, 1, 1, 0, 11'h111, 2'd1, "R2");

    // R4 jump with page, R7 bubble ignores a jump
    step(1, 1, 0, 0, 0, 11'h123, 2'd2, "R4");
    step(1, 1, 0, 0, 0, 11'h3AA, 2'd1, "R7");
    plain("R4");

    // R3 alias at the 2K boundary and carry into the page bits
    step(1, 1, 0, 0, 0, 11'h7FE, 2'd0, "R4");
    plain("R7");
    plain("R3"); plain("R3");
    step(1, 1, 0, 0, 0, 11'h7FF, 2'd1, "R4");
    plain("R7");
    plain("R3");
    // R2: 13-bit wrap
    step(1, 1, 0, 0, 0, 11'h7FE, 2'd3, "R2");
    plain("R7");
    plain("R2"); plain("R2");

    // R5 call and return
    step(1, 1, 0, 0, 0, 11'h222, 2'd2, "R4");
    plain("R7");
    step(1, 0, 1, 0, 0, 11'h050, 2'd0, "R5");
    plain("R7");
    plain("R5");
    step(1, 0, 0, 1, 0, 11'h0, 2'd0, "R5");
    plain("R7");
    plain("R5");

    // R6 interrupt beats a same-cycle jump, then returns
    step(1, 1, 0, 0, 1, 11'h300, 2'd1, "R6");
    plain("R7");
    plain("R6");
    step(1, 0, 0, 1, 0, 11'h0, 2'd0, "R6");
    plain("R7");

    // R9 interrupt pulse during a bubble, then while advance is low
    step(1, 1, 0, 0, 0, 11'h400, 2'd0, "R4");
    step(1, 1, 0, 0, 1, 11'h010, 2'd0, "R9");
    plain("R9");
    plain("R7");
    step(1, 0, 0, 1, 0, 11'h0, 2'd0, "R5");
    plain("R7");
    step(0, 0, 0, 0, 1, 11'h0, 2'd0, "R9");
    step(0, 0, 0, 0, 0, 11'h0, 2'd0, "R9");
    plain("R9");
    plain("R7");
    step(1, 0, 0, 1, 0, 11'h0, 2'd0, "R5");
    plain("R7");

    // R10 priority: return over call, call over jump
    step(1, 0, 1, 0, 0, 11'h600, 2'd1, "R5");
    plain("R7");
    step(1, 1, 1, 1, 0, 11'h700, 2'd2, "R10");
    plain("R7");
    step(1, 1, 1, 0, 0, 11'h0AB, 2'd3, "R10");
    plain("R7");
    step(1, 0, 0, 1, 0, 11'h0, 2'd0, "R10");
    plain("R7");

    // R8: nine nested calls, nine returns, wrapped stack
    for (int k = 0; k < 9; k++) begin
      step(1, 0, 1, 0, 0, 11'(16 * k + 3), 2'(k % 4), "R8");
      plain("R8");
    end
    for (int k = 0; k < 9; k++) begin
      step(1, 0, 0, 1, 0, 11'h0, 2'd0, "R8");
      plain("R8");
    end

    // R1: reset wins over a simultaneous interrupt
    doReset(1'b1);
    plain("R1");
    plain("R1");

    @(negedge clk);
    advance = 1'b0;
    @(posedge clk);
    #2;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule